// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block sits beside the main command arbiter of a DDR2-style memory controller. It keeps the memory refreshed. A free-running interval timer produces one owed refresh every `T_REFI` clock cycles. The owed refreshes go into a saturating counter. While refreshes are owed, the block raises a low-priority request to the arbiter, so the host can let traffic finish and postpone refreshes. Once eight refreshes are owed, no more may be postponed. The block then raises an urgent request that the arbiter must serve ahead of normal traffic. This limit keeps the gap between two refreshes within nine intervals.

When the arbiter grants the request, the block owns the command bus for one refresh sequence:

- In the first cycle it issues a precharge-all command, but only if some bank is still open. If every bank is idle, that cycle carries a no-op.
- It then lets the precharge time `T_RP` run.
- It issues one auto-refresh command. The address lines are don't-care, apart from the A10 flag driven here.
- It holds `busy` high until the refresh cycle time `T_RFC` has elapsed. While `busy` is high, the arbiter must issue no activate and no other refresh.

A build option makes the block issue the precharge-all in every sequence, whatever the bank state.

Top module: `refresh_sched`

## Requirements
- R1: During and directly after reset, `req`, `urgent` and `busy` are low. The command outputs carry the no-op encoding (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, `a10`=0), and `cke` is high at all times.
- R2: The timer adds one owed refresh on every `T_REFI`-th clock edge after reset. With nothing granted, `req` is low after edge `T_REFI`-1 and high after edge `T_REFI`.
- R3: Each auto-refresh command pays back one owed refresh. `req` is high only while refreshes are owed and no sequence is running, and it falls once the last owed refresh has been issued.
- R4: `urgent` is high exactly when eight refreshes are owed and no sequence is running. It implies `req`, and it falls once a refresh brings the count below eight.
- R5: The owed count saturates at eight. An interval that expires while eight are owed adds nothing, so one refresh brings the count back to seven.
- R6: In the first cycle after an accepted grant (grant and `req` both high on a clock edge), the block drives a precharge-all (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1) if `banks_idle` was low at the grant. If `banks_idle` was high, it drives a no-op.
- R7: The auto-refresh command (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1) appears exactly `T_RP` cycles after that first cycle, with no-ops in between.
- R8: `busy` is high from the first sequence cycle until `T_RFC` cycles after the auto-refresh command, with no-ops throughout that wait. With the grant held high, successive auto-refresh commands are `T_RP`+`T_RFC`+1 cycles apart.
- R9: A grant while `req` is low, or while `busy` is high, starts no sequence and changes no output.
- R10: With `ALWAYS_PRE`=1, the first sequence cycle carries the precharge-all even when `banks_idle` is high. All other timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when every bank is precharged |
| grant | input | 1 | Arbiter hands the command bus to the scheduler |
| req | output | 1 | Refresh owed, low priority |
| urgent | output | 1 | Postponement limit reached, must be served |
| busy | output | 1 | Refresh sequence running; blocks activates and refreshes |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a10 | output | 1 | All-banks flag for precharge |
| dram_cke | output | 1 | Clock enable, held high |

## Verification
A wrong owed count shows at the ports as a shifted edge of `req` or `urgent`, or as the wrong number of refreshes before `req` falls. For that reason the bench drains the full backlog and counts the commands issued. A miscounted `T_RP` or `T_RFC` wait moves the auto-refresh command, or the falling edge of `busy`, by whole cycles within the same sequence. Each cycle of a sequence is therefore sampled, and so is the spacing of back-to-back refreshes. A lost precharge decision shows on the first command after the grant.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

   // Command bus seen by the memory: {cs_n, ras_n, cas_n, we_n, a10}
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic a10;
   } dram_cmd_t;

   localparam dram_cmd_t CMD_NOP    = 5'b01110;
   localparam dram_cmd_t CMD_PREALL = 5'b00101;
   localparam dram_cmd_t CMD_AREF   = 5'b00010;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_WAIT_RP,
      SQ_REFRESH,
      SQ_WAIT_RFC
   } seq_state_t;

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int unsigned T_REFI = 3120
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned TW = (T_REFI > 1) ? $clog2(T_REFI) : 1;
   localparam logic [TW-1:0] RELOAD = TW'(T_REFI - 1);

   logic [TW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= RELOAD;
      end else if (remain == '0) begin
         remain <= RELOAD;
      end else begin
         remain <= remain - 1'b1;
      end
   end

   assign tick = (remain == '0);

endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
   parameter int unsigned MAX_OWED = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic add_one,
   input  logic pay_one,
   output logic pending,
   output logic full
);
   localparam int unsigned OW = $clog2(MAX_OWED + 1);
   localparam logic [OW-1:0] LIMIT = OW'(MAX_OWED);

   logic [OW-1:0] owed;

   assign pending = (owed != '0);
   assign full    = (owed == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owed <= '0;
      end else begin
         unique case ({add_one, pay_one})
            2'b10:   if (!full)   owed <= owed + 1'b1;
            2'b01:   if (pending) owed <= owed - 1'b1;
            default: owed <= owed;
         endcase
      end
   end

endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
   import refresh_pkg::*;
#(
   parameter int unsigned T_RP       = 6,
   parameter int unsigned T_RFC      = 52,
   parameter bit          ALWAYS_PRE = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      banks_idle,
   output dram_cmd_t cmd,
   output logic      busy,
   output logic      ref_issue
);
   localparam int unsigned T_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int unsigned CW    = $clog2(T_MAX);
   localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 2);
   localparam logic [CW-1:0] RFC_LOAD = CW'(T_RFC - 2);

   seq_state_t    st;
   logic [CW-1:0] wait_cnt;
   logic          need_pre;
   logic          close_rows;

   generate
      if (ALWAYS_PRE) begin : g_pre_always
         assign close_rows = 1'b1;
      end else begin : g_pre_open
         assign close_rows = ~banks_idle;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         wait_cnt <= '0;
         need_pre <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  st       <= SQ_SETUP;
                  need_pre <= close_rows;
               end
            end
            SQ_SETUP: begin
               st       <= SQ_WAIT_RP;
               wait_cnt <= RP_LOAD;
            end
            SQ_WAIT_RP: begin
               if (wait_cnt == '0) st <= SQ_REFRESH;
               else                wait_cnt <= wait_cnt - 1'b1;
            end
            SQ_REFRESH: begin
               st       <= SQ_WAIT_RFC;
               wait_cnt <= RFC_LOAD;
               need_pre <= 1'b0;
            end
            SQ_WAIT_RFC: begin
               if (wait_cnt == '0) st <= SQ_IDLE;
               else                wait_cnt <= wait_cnt - 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         SQ_SETUP:   cmd = need_pre ? CMD_PREALL : CMD_NOP;
         SQ_REFRESH: cmd = CMD_AREF;
         default:    cmd = CMD_NOP;
      endcase
   end

   assign busy      = (st != SQ_IDLE);
   assign ref_issue = (st == SQ_REFRESH);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refresh_pkg::*;
#(
   parameter int unsigned T_REFI     = 3120,
   parameter int unsigned T_RP       = 6,
   parameter int unsigned T_RFC      = 52,
   parameter int unsigned MAX_OWED   = 8,
   parameter bit          ALWAYS_PRE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic banks_idle,
   input  logic grant,
   output logic req,
   output logic urgent,
   output logic busy,
   output logic dram_cs_n,
   output logic dram_ras_n,
   output logic dram_cas_n,
   output logic dram_we_n,
   output logic dram_a10,
   output logic dram_cke
);
   generate
      if (T_RP < 2) begin : g_bad_rp
         $error("T_RP must be at least 2 cycles");
      end
      if (T_RFC < 2) begin : g_bad_rfc
         $error("T_RFC must be at least 2 cycles");
      end
      if (MAX_OWED < 1) begin : g_bad_owed
         $error("MAX_OWED must be at least 1");
      end
      if (T_REFI <= T_RP + T_RFC + 1) begin : g_bad_refi
         $error("T_REFI must exceed one full refresh sequence");
      end
   endgenerate

   logic      tick;
   logic      pending;
   logic      full;
   logic      start;
   logic      seq_busy;
   logic      ref_issue;
   dram_cmd_t cmd;

   rfs_interval_timer #(
      .T_REFI(T_REFI)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfs_owed_counter #(
      .MAX_OWED(MAX_OWED)
   ) owed_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_one (tick),
      .pay_one (ref_issue),
      .pending (pending),
      .full    (full)
   );

   rfs_sequencer #(
      .T_RP       (T_RP),
      .T_RFC      (T_RFC),
      .ALWAYS_PRE (ALWAYS_PRE)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .banks_idle (banks_idle),
      .cmd        (cmd),
      .busy       (seq_busy),
      .ref_issue  (ref_issue)
   );

   assign req    = pending & ~seq_busy;
   assign urgent = full & ~seq_busy;
   assign start  = grant & req;
   assign busy   = seq_busy;

   assign dram_cs_n  = cmd.cs_n;
   assign dram_ras_n = cmd.ras_n;
   assign dram_cas_n = cmd.cas_n;
   assign dram_we_n  = cmd.we_n;
   assign dram_a10   = cmd.a10;
   assign dram_cke   = 1'b1;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int unsigned T_RP  = 6,
   parameter int unsigned T_RFC = 52
) (
   input logic clk,
   input logic rst_n,
   input logic grant,
   input logic req,
   input logic urgent,
   input logic busy,
   input logic dram_cs_n,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_a10
);
   localparam int unsigned RW = $clog2(T_RFC + 1);
   localparam int unsigned BW = $clog2(T_RP + 2);
   localparam logic [RW-1:0] RFC_V = RW'(T_RFC);
   localparam logic [BW-1:0] RP_V  = BW'(T_RP);
   localparam logic [BW-1:0] RP_SAT = BW'(T_RP + 1);

   logic          is_ar;
   logic          is_pre;
   logic [RW-1:0] since_ref;
   logic [BW-1:0] since_busy;

   assign is_ar  = !dram_cs_n && !dram_ras_n && !dram_cas_n && dram_we_n;
   assign is_pre = !dram_cs_n && !dram_ras_n && dram_cas_n && !dram_we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ref  <= RFC_V;
         since_busy <= '0;
      end else begin
         if (is_ar)                since_ref <= RW'(1);
         else if (since_ref != RFC_V) since_ref <= since_ref + 1'b1;
         if (!busy)                since_busy <= '0;
         else if (since_busy != RP_SAT) since_busy <= since_busy + 1'b1;
      end
   end

   // R8
   ar_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ar |-> (since_ref == RFC_V));

   // R8
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (since_ref == RFC_V));

   // R7
   ar_after_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ar |-> (busy && since_busy == RP_V));

   // R6
   pre_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (busy && since_busy == '0 && dram_a10));

   // R4
   urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urgent |-> req);

   // R9
   start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(grant && req));

endmodule

bind refresh_sched refresh_sched_chk #(
   .T_RP  (T_RP),
   .T_RFC (T_RFC)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .grant      (grant),
   .req        (req),
   .urgent     (urgent),
   .busy       (busy),
   .dram_cs_n  (dram_cs_n),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_a10   (dram_a10)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
   localparam int T_REFI = 200;
   localparam int T_RP   = 3;
   localparam int T_RFC  = 6;
   localparam int LIMIT  = 8;
   localparam logic [4:0] C_NOP = 5'b01110;
   localparam logic [4:0] C_PRE = 5'b00101;
   localparam logic [4:0] C_AR  = 5'b00010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic banks_idle = 1'b0;
   logic grant = 1'b0;
   logic req, urgent, busy, cs_n, ras_n, cas_n, we_n, a10, cke;
   logic p_req, p_urgent, p_busy, p_cs_n, p_ras_n, p_cas_n, p_we_n, p_a10, p_cke;

   int checks = 0;
   int errors = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   refresh_sched #(.T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC),
                   .MAX_OWED(LIMIT), .ALWAYS_PRE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .grant(grant),
      .req(req), .urgent(urgent), .busy(busy),
      .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_a10(a10), .dram_cke(cke));

   refresh_sched #(.T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC),
                   .MAX_OWED(LIMIT), .ALWAYS_PRE(1'b1)) uut_pre (
      .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .grant(grant),
      .req(p_req), .urgent(p_urgent), .busy(p_busy),
      .dram_cs_n(p_cs_n), .dram_ras_n(p_ras_n), .dram_cas_n(p_cas_n),
      .dram_we_n(p_we_n), .dram_a10(p_a10), .dram_cke(p_cke));

   function automatic logic [4:0] cmd_now();
      return {cs_n, ras_n, cas_n, we_n, a10};
   endfunction

   function automatic logic [4:0] pcmd_now();
      return {p_cs_n, p_ras_n, p_cas_n, p_we_n, p_a10};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d @edge %0d", tag, what, act, exp, edges);
      end
   endtask

   task automatic at_edge(input int n);
      do @(negedge clk); while (edges < n);
   endtask

   // cke stays high every cycle (R1)
   always @(negedge clk) if (!done) begin
      if (cke !== 1'b1 || p_cke !== 1'b1) chk(1'b0, "R1", "cke", int'(cke), 1);
   end

   initial begin
      #(200000 * 10);
      chk(1'b0, "WATCHDOG", "timeout", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ar_cnt, pre_cnt, p_pre_cnt, last_ar, first_ar, bad_gap, stray;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(req == 0 && urgent == 0 && busy == 0, "R1", "flags in reset",
          int'({req, urgent, busy}), 0);
      chk(cmd_now() == C_NOP, "R1", "cmd in reset", int'(cmd_now()), int'(C_NOP));
      rst_n = 1'b1;
      at_edge(1);
      chk(req == 0 && busy == 0 && cmd_now() == C_NOP, "R1", "after reset",
          int'({req, busy}), 0);

      // R2: first interval
      at_edge(T_REFI - 1);
      chk(req == 0, "R2", "req before interval", int'(req), 0);
      at_edge(T_REFI);
      chk(req == 1 && urgent == 0, "R2", "req after interval", int'({req, urgent}), 2);

      // R4: urgent exactly when limit owed
      at_edge(LIMIT * T_REFI - 1);
      chk(urgent == 0 && req == 1, "R4", "urgent before limit", int'({req, urgent}), 2);
      at_edge(LIMIT * T_REFI);
      chk(urgent == 1 && req == 1, "R4", "urgent at limit", int'({req, urgent}), 3);
      at_edge((LIMIT + 1) * T_REFI);
      chk(urgent == 1, "R5", "urgent after extra interval", int'(urgent), 1);

      // one refresh with banks open: grant sampled at edge G
      at_edge((LIMIT + 1) * T_REFI + 5);
      grant = 1'b1;
      at_edge((LIMIT + 1) * T_REFI + 6);
      grant = 1'b0;
      chk(cmd_now() == C_PRE && busy == 1 && req == 0, "R6", "precharge-all first cycle",
          int'(cmd_now()), int'(C_PRE));
      for (int k = 1; k < T_RP; k++) begin
         at_edge((LIMIT + 1) * T_REFI + 6 + k);
         chk(cmd_now() == C_NOP && busy == 1, "R7", "nop in tRP wait", int'(cmd_now()), int'(C_NOP));
      end
      at_edge((LIMIT + 1) * T_REFI + 6 + T_RP);
      chk(cmd_now() == C_AR && busy == 1, "R7", "auto-refresh after tRP", int'(cmd_now()), int'(C_AR));
      banks_idle = 1'b1;
      for (int k = 1; k < T_RFC; k++) begin
         at_edge((LIMIT + 1) * T_REFI + 6 + T_RP + k);
         chk(cmd_now() == C_NOP && busy == 1, "R8", "busy through tRFC", int'(busy), 1);
      end
      at_edge((LIMIT + 1) * T_REFI + 6 + T_RP + T_RFC);
      chk(busy == 0 && req == 1, "R8", "busy released", int'({busy, req}), 1);
      chk(urgent == 0, "R5", "urgent clears after one refresh (saturated at 8)", int'(urgent), 0);
      chk(p_busy == 0 && p_urgent == 0, "R10", "variant same timing", int'({p_busy, p_urgent}), 0);

      // drain the remaining seven with grant held, banks idle
      at_edge((LIMIT + 1) * T_REFI + 30);
      grant = 1'b1;
      ar_cnt = 0; pre_cnt = 0; p_pre_cnt = 0; last_ar = -1; first_ar = -1; bad_gap = 0;
      while (edges < (LIMIT + 1) * T_REFI + 105) begin
         at_edge(edges + 1);
         if (cmd_now() == C_AR) begin
            if (first_ar < 0) first_ar = edges;
            if (last_ar >= 0 && edges - last_ar != T_RP + T_RFC + 1) bad_gap++;
            last_ar = edges;
            ar_cnt++;
         end
         if (cmd_now() == C_PRE) pre_cnt++;
         if (pcmd_now() == C_PRE) p_pre_cnt++;
      end
      chk(ar_cnt == LIMIT - 1, "R3", "refreshes to clear backlog", ar_cnt, LIMIT - 1);
      chk(first_ar == (LIMIT + 1) * T_REFI + 31 + T_RP, "R7", "first drained refresh edge",
          first_ar, (LIMIT + 1) * T_REFI + 31 + T_RP);
      chk(bad_gap == 0, "R8", "back-to-back refresh spacing errors", bad_gap, 0);
      chk(pre_cnt == 0, "R6", "no precharge when banks idle", pre_cnt, 0);
      chk(p_pre_cnt == LIMIT - 1, "R10", "variant always precharges", p_pre_cnt, LIMIT - 1);
      chk(req == 0 && busy == 0, "R3", "req low when paid up", int'({req, busy}), 0);

      // R9: grant held with nothing owed does nothing
      stray = 0;
      while (edges < (LIMIT + 1) * T_REFI + 160) begin
         at_edge(edges + 1);
         if (busy != 0 || cmd_now() != C_NOP) stray++;
      end
      chk(stray == 0, "R9", "grant without request ignored", stray, 0);
      grant = 1'b0;

      at_edge((LIMIT + 2) * T_REFI - 1);
      chk(req == 0, "R2", "req before next interval", int'(req), 0);
      at_edge((LIMIT + 2) * T_REFI);
      chk(req == 1 && urgent == 0, "R2", "req at next interval", int'({req, urgent}), 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule